// File: doc/BRIEF.md
# Parallel Display Bus Write Bridge

The bridge sits on a simple valid/ready register bus. It turns CPU register writes into write cycles on a 16-bit parallel bus that feeds a display controller. It claims a 16-byte window at a base address set by a parameter. Inside that window it decodes three offsets: offset 0x0 resets the display, offset 0x8 sends a command word, and offset 0xC sends pixel data. A 32-bit pixel write becomes two back-to-back pixel cycles. Accesses outside the window, reads, and unused offsets are accepted and cause no activity on the display bus.

A single state machine drives the display side. It has the states IDLE, SETUP, STROBE, HOLD and RESET, with these transitions:

- IDLE→SETUP when a command or pixel write is accepted.
- IDLE→RESET when a write to offset 0x0 has bit 0 set.
- SETUP→STROBE, then STROBE→HOLD, each when that phase's down-counter reaches zero.
- HOLD→SETUP when the upper pixel of a wide write is still pending.
- HOLD→IDLE when nothing is pending.
- RESET→IDLE when the pulse counter expires.

The bus is ready only in IDLE, so a request that arrives while the machine is busy waits with ready low.

Top module: `lcd_bus_bridge`

## Requirements
- R1: Only addresses from BASE to BASE+0xF are claimed. A write elsewhere is accepted but produces no display cycle and no reset pulse.
- R2: A write to offset 0x0 with bit 0 set drives `lcd_rst_n` low for RESET_CYC clocks (default 16), with chip select and write strobe high throughout. A write to offset 0x0 with bit 0 clear has no effect.
- R3: A write to offset 0x8 produces one write cycle carrying wdata[15:0] with `lcd_dc` low (command level). The size flag is ignored.
- R4: A 16-bit write (`req_wide`=0) to offset 0xC produces one write cycle carrying wdata[15:0] with `lcd_dc` high (data level).
- R5: A 32-bit write (`req_wide`=1) to offset 0xC produces two pixel cycles with `lcd_dc` high: wdata[15:0] first, then wdata[31:16].
- R6: In each cycle, chip select is low for SETUP_CYC clocks (default 2) before the write strobe falls. The strobe stays low for STROBE_CYC clocks (default 2). Chip select stays low for HOLD_CYC clocks (default 2) after the strobe rises. The write strobe is never low while chip select is high.
- R7: `lcd_data` and `lcd_dc` stay constant while the write strobe is low, and across the hold phase of a cycle.
- R8: `req_ready` is low while a display cycle or reset pulse is in progress. A request held during that time is accepted on the first clock after the machine returns to IDLE. With default timing, a request that follows a single cycle waits 5 sampled clocks and one that follows a reset pulse waits 15.
- R9: `lcd_rd_n` is high at all times. `req_rdata` is zero. A read at any offset, or a write to offset 0x4, produces no display activity.
- R10: During and directly after system reset, `req_ready`, `lcd_rst_n`, `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are all high.
- R11: A write with all four byte strobes clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | ADDR_W | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte write strobes |
| req_wide | input | 1 | Size flag: 1 = 32-bit access, 0 = 16-bit |
| req_rdata | output | 32 | Read data (always zero) |
| lcd_rst_n | output | 1 | Display reset, active low |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low (held high) |
| lcd_dc | output | 1 | 0 = command, 1 = data |
| lcd_data | output | 16 | Display data bus |

## Verification
On every clock, the assertions check the following:
- the write strobe stays inside chip select;
- data and the data/command line stay frozen while the strobe is low;
- no bus cycle overlaps the reset pulse;
- ready is low whenever the display side is active;
- the strobe is entered only from setup.

Only the bench scenarios can show the rest:
- which offset maps to which action;
- the word order of a wide pixel write;
- the exact setup, strobe, hold and reset lengths;
- that out-of-window, read and strobe-less accesses leave the bus untouched;
- how long a blocked request waits.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

    localparam int PIX_W = 16;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RESET,
        OP_CMD,
        OP_PIXEL
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RESET
    } state_e;

    typedef struct packed {
        op_e              op;
        logic             two;
        logic [PIX_W-1:0] lo;
        logic [PIX_W-1:0] hi;
    } job_t;

endpackage

// File: rtl/lcdb_decode.sv
module lcdb_decode
    import lcdb_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'h43C0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [3:0]        wstrb,
    input  logic              wide,
    input  logic [31:0]       wdata,
    output job_t              job
);
    localparam int             OFS_W     = 4;
    localparam logic [OFS_W-1:0] OFS_RESET = 4'h0;
    localparam logic [OFS_W-1:0] OFS_CMD   = 4'h8;
    localparam logic [OFS_W-1:0] OFS_PIX   = 4'hC;

    logic             hit;
    logic [OFS_W-1:0] ofs;

    always_comb begin
        // window match on upper bits, write with at least one byte lane
        hit = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]) && we && (|wstrb);
        ofs = addr[OFS_W-1:0];
        job = '{op: OP_NONE, two: 1'b0, lo: wdata[PIX_W-1:0], hi: wdata[31:PIX_W]};
        if (hit) begin
            unique case (ofs)
                OFS_RESET: if (wdata[0]) job.op = OP_RESET;
                OFS_CMD:   job.op = OP_CMD;
                OFS_PIX: begin
                    job.op  = OP_PIXEL;
                    job.two = wide;
                end
                default: job.op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
    import lcdb_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 2,
    parameter int RESET_CYC  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  job_t             job,
    output logic             ready,
    output logic             lcd_rst_n,
    output logic             lcd_cs_n,
    output logic             lcd_wr_n,
    output logic             lcd_dc,
    output logic [PIX_W-1:0] lcd_data
);
    localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_B = (HOLD_CYC > RESET_CYC) ? HOLD_CYC : RESET_CYC;
    localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

    localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RESET_LAST  = CNT_W'(RESET_CYC - 1);

    state_e           state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             pend, pend_nx;
    logic             dc_q, dc_nx;
    logic [PIX_W-1:0] word_q, word_nx;
    logic [PIX_W-1:0] hi_q, hi_nx;
    logic             cnt_done;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            pend   <= 1'b0;
            dc_q   <= 1'b1;
            word_q <= '0;
            hi_q   <= '0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            pend   <= pend_nx;
            dc_q   <= dc_nx;
            word_q <= word_nx;
            hi_q   <= hi_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        pend_nx  = pend;
        dc_nx    = dc_q;
        word_nx  = word_q;
        hi_nx    = hi_q;
        cnt_done = (cnt == '0);
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    unique case (job.op)
                        OP_RESET: begin
                            state_nx = ST_RESET;
                            cnt_nx   = RESET_LAST;
                        end
                        OP_CMD: begin
                            state_nx = ST_SETUP;
                            cnt_nx   = SETUP_LAST;
                            dc_nx    = 1'b0;
                            word_nx  = job.lo;
                            pend_nx  = 1'b0;
                        end
                        OP_PIXEL: begin
                            state_nx = ST_SETUP;
                            cnt_nx   = SETUP_LAST;
                            dc_nx    = 1'b1;
                            word_nx  = job.lo;
                            hi_nx    = job.hi;
                            pend_nx  = job.two;
                        end
                        default: state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_SETUP: begin
                if (cnt_done) begin
                    state_nx = ST_STROBE;
                    cnt_nx   = STROBE_LAST;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_done) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = HOLD_LAST;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (cnt_done) begin
                    if (pend) begin
                        state_nx = ST_SETUP;
                        cnt_nx   = SETUP_LAST;
                        word_nx  = hi_q;
                        pend_nx  = 1'b0;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_RESET: begin
                if (cnt_done) state_nx = ST_IDLE;
                else          cnt_nx   = cnt - CNT_W'(1);
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = (state == ST_IDLE);
        lcd_rst_n = (state != ST_RESET);
        lcd_cs_n  = !((state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD));
        lcd_wr_n  = (state != ST_STROBE);
        lcd_dc    = dc_q;
        lcd_data  = word_q;
    end

    p_wr_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> !lcd_cs_n);

    p_strobe_after_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_wr_n) |-> $past(state) == ST_SETUP);

    p_data_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n && $past(!lcd_wr_n)) |-> ($stable(lcd_data) && $stable(lcd_dc)));

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_STROBE) |-> ($stable(lcd_data) && $stable(lcd_dc)));

    p_quiet_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (lcd_cs_n && lcd_wr_n));

    p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n || !lcd_rst_n) |-> !ready);

    p_second_is_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HOLD && state == ST_SETUP) |-> lcd_dc);

endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge
    import lcdb_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BASE       = 32'h43C0_0000,
    parameter int                SETUP_CYC  = 2,
    parameter int                STROBE_CYC = 2,
    parameter int                HOLD_CYC   = 2,
    parameter int                RESET_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_wstrb,
    input  logic              req_wide,
    output logic [31:0]       req_rdata,
    output logic              lcd_rst_n,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic              lcd_dc,
    output logic [PIX_W-1:0]  lcd_data
);
    job_t job;
    logic start;

    lcdb_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_decode (
        .addr  (req_addr),
        .we    (req_we),
        .wstrb (req_wstrb),
        .wide  (req_wide),
        .wdata (req_wdata),
        .job   (job)
    );

    assign start = req_valid && req_ready;

    lcdb_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .RESET_CYC  (RESET_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .job       (job),
        .ready     (req_ready),
        .lcd_rst_n (lcd_rst_n),
        .lcd_cs_n  (lcd_cs_n),
        .lcd_wr_n  (lcd_wr_n),
        .lcd_dc    (lcd_dc),
        .lcd_data  (lcd_data)
    );

    assign lcd_rd_n  = 1'b1;
    assign req_rdata = '0;

    p_accept_leaves_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && job.op != OP_NONE) |=> !req_ready);

    p_ignored_stays_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && job.op == OP_NONE) |=> (req_ready && lcd_cs_n && lcd_rst_n));

endmodule

// File: tb/lcd_bus_bridge_bench.sv
module lcd_bus_bridge_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h43C0_0000;
    localparam int          NVEC       = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic        wide;
        logic [31:0] data;
        logic [1:0]  ncyc;
        logic [15:0] w0;
        logic        dc0;
        logic [15:0] w1;
        logic        rst;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{BASE + 32'h8,  1'b0, 32'h0000_1234, 2'd1, 16'h1234, 1'b0, 16'h0000, 1'b0}, // R3
        '{BASE + 32'hC,  1'b0, 32'h0000_ABCD, 2'd1, 16'hABCD, 1'b1, 16'h0000, 1'b0}, // R4
        '{BASE + 32'hC,  1'b1, 32'h5555_AAAA, 2'd2, 16'hAAAA, 1'b1, 16'h5555, 1'b0}, // R5
        '{BASE,          1'b0, 32'h0000_0001, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R2
        '{BASE,          1'b0, 32'h0000_0002, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R2
        '{BASE + 32'h1C, 1'b0, 32'h0000_7777, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R1
        '{BASE - 32'h4,  1'b0, 32'h0000_0001, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R1
        '{BASE + 32'h4,  1'b0, 32'h0000_0001, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R9
        '{BASE + 32'h8,  1'b1, 32'hDEAD_0042, 2'd1, 16'h0042, 1'b0, 16'h0000, 1'b0}, // R3
        '{BASE + 32'hC,  1'b1, 32'h0001_FFFE, 2'd2, 16'hFFFE, 1'b1, 16'h0001, 1'b0}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_wstrb = '0;
    logic        req_wide = 1'b0;
    logic [31:0] req_rdata;
    logic        lcd_rst_n, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc;
    logic [15:0] lcd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string vtag [NVEC] = '{"R3", "R4", "R5", "R2", "R2", "R1", "R1", "R9", "R3", "R5"};

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_bus_bridge #(.BASE(BASE)) u_lcd_bus_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .req_wstrb (req_wstrb),
        .req_wide  (req_wide),
        .req_rdata (req_rdata),
        .lcd_rst_n (lcd_rst_n),
        .lcd_cs_n  (lcd_cs_n),
        .lcd_wr_n  (lcd_wr_n),
        .lcd_rd_n  (lcd_rd_n),
        .lcd_dc    (lcd_dc),
        .lcd_data  (lcd_data)
    );

    // display-side monitor, sampled on the falling edge
    logic [15:0] log_data [64];
    logic        log_dc   [64];
    int          log_wl   [64];
    int          log_pre  [64];
    bit          log_bad  [64];
    int nlog = 0, wl = 0, pre = 0, post = 0, last_post = 0, pre_at_fall = 0;
    int rst_run = 0, rst_len = 0, rst_pulses = 0;
    bit prev_wr = 1'b1, prev_cs = 1'b1, prev_rst = 1'b1, unstable = 1'b0;
    bit rd_low_seen = 1'b0, cs_in_rst = 1'b0, wr_outside_cs = 1'b0;
    logic [15:0] fall_data;
    logic        fall_dc;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!lcd_rd_n) rd_low_seen = 1'b1;
            if (!lcd_rst_n && !lcd_cs_n) cs_in_rst = 1'b1;
            if (!lcd_wr_n) begin
                if (lcd_cs_n) wr_outside_cs = 1'b1;
                if (prev_wr) begin
                    fall_data   = lcd_data;
                    fall_dc     = lcd_dc;
                    unstable    = 1'b0;
                    pre_at_fall = pre;
                end else if (lcd_data !== fall_data || lcd_dc !== fall_dc) begin
                    unstable = 1'b1;
                end
                pre = 0;
                wl++;
            end else if (!prev_wr) begin
                if (nlog < 64) begin
                    log_data[nlog] = fall_data;
                    log_dc[nlog]   = fall_dc;
                    log_wl[nlog]   = wl;
                    log_pre[nlog]  = pre_at_fall;
                    log_bad[nlog]  = unstable;
                    nlog++;
                end
                wl   = 0;
                post = 0;
            end
            if (lcd_cs_n) begin
                if (!prev_cs) last_post = post;
                pre = 0;
            end else if (lcd_wr_n) begin
                if (!prev_wr || post > 0 || pre >= 0) post++;
                pre++;
            end
            if (!lcd_rst_n) rst_run++;
            else if (!prev_rst) begin
                rst_len = rst_run;
                rst_pulses++;
                rst_run = 0;
            end
            prev_wr  = lcd_wr_n;
            prev_cs  = lcd_cs_n;
            prev_rst = lcd_rst_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // issue one access; waits = falling-edge samples spent with ready low
    task automatic access(input logic [31:0] a, input logic we, input logic wide,
                          input logic [31:0] d, input logic [3:0] st, output int waits);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_we    = we;
        req_wide  = wide;
        req_wdata = d;
        req_wstrb = st;
        waits     = 0;
        while (!req_ready) begin
            @(negedge clk);
            waits++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w, w2, base, pulses;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 ready in reset", {31'b0, req_ready}, 32'd1);
        chk("R10 idle lines in reset", {27'b0, lcd_rst_n, lcd_cs_n, lcd_wr_n, lcd_rd_n, 1'b1}, 32'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle lines after reset",
            {26'b0, req_ready, lcd_rst_n, lcd_cs_n, lcd_wr_n, lcd_rd_n, 1'b1}, 32'h3F);

        // table of vectors
        for (int i = 0; i < NVEC; i++) begin
            base   = nlog;
            pulses = rst_pulses;
            access(VECS[i].addr, 1'b1, VECS[i].wide, VECS[i].data, 4'hF, w);
            settle();
            chk({vtag[i], " cycle count"}, nlog - base, {30'b0, VECS[i].ncyc});
            chk({vtag[i], " reset pulses"}, rst_pulses - pulses, {31'b0, VECS[i].rst});
            if (VECS[i].rst) chk("R2 reset length", rst_len, 32'd16);
            if (VECS[i].ncyc >= 1 && nlog - base >= 1) begin
                chk({vtag[i], " first word"}, {16'b0, log_data[base]}, {16'b0, VECS[i].w0});
                chk({vtag[i], " first dc"}, {31'b0, log_dc[base]}, {31'b0, VECS[i].dc0});
                chk("R6 strobe width", log_wl[base], 32'd2);
            end
            if (VECS[i].ncyc == 2 && nlog - base >= 2) begin
                chk({vtag[i], " second word"}, {16'b0, log_data[base+1]}, {16'b0, VECS[i].w1});
                chk({vtag[i], " second dc"}, {31'b0, log_dc[base+1]}, 32'd1);
                chk("R6 second strobe width", log_wl[base+1], 32'd2);
            end
        end

        // R6/R7: single cycle timing and stability
        base = nlog;
        access(BASE + 32'hC, 1'b1, 1'b0, 32'h0000_3C3C, 4'h3, w);
        settle();
        chk("R6 setup before strobe", log_pre[base], 32'd2);
        chk("R6 hold after strobe", last_post, 32'd2);
        chk("R7 data stable in strobe", {31'b0, log_bad[base]}, 32'd0);

        // R8: back-to-back pixel then command, second request stalls
        base = nlog;
        access(BASE + 32'hC, 1'b1, 1'b0, 32'h0000_1111, 4'hF, w);
        access(BASE + 32'h8, 1'b1, 1'b0, 32'h0000_2222, 4'hF, w2);
        settle();
        chk("R8 wait after one cycle", w2, 32'd5);
        chk("R8 order first", {16'b0, log_data[base]}, 32'h1111);
        chk("R8 order second", {16'b0, log_data[base+1]}, 32'h2222);

        // R8/R2: request behind a reset pulse
        base   = nlog;
        pulses = rst_pulses;
        access(BASE, 1'b1, 1'b0, 32'h0000_0001, 4'h1, w);
        access(BASE + 32'h8, 1'b1, 1'b0, 32'h0000_0033, 4'hF, w2);
        settle();
        chk("R8 wait after reset pulse", w2, 32'd15);
        chk("R2 reset then command", {16'b0, log_data[base]}, 32'h0033);
        chk("R2 reset pulse count", rst_pulses - pulses, 32'd1);

        // R9: read returns zero and causes no cycle
        base = nlog;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = BASE + 32'hC; req_wstrb = 4'hF;
        chk("R9 read data zero", req_rdata, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        settle();
        chk("R9 read no cycle", nlog - base, 32'd0);

        // R11: no byte strobes
        base = nlog;
        access(BASE + 32'hC, 1'b1, 1'b0, 32'h0000_9999, 4'h0, w);
        settle();
        chk("R11 strobe-less write dropped", nlog - base, 32'd0);

        chk("R9 read strobe never low", {31'b0, rd_low_seen}, 32'd0);
        chk("R2 no cycle during reset", {31'b0, cs_in_rst}, 32'd0);
        chk("R6 strobe only inside select", {31'b0, wr_outside_cs}, 32'd0);

        finish_run();
    end

endmodule